// File: doc/BRIEF.md
# UART interrupt priority identifier

This block sits between the status logic of a UART and the host bus. It holds the four-bit interrupt-enable register and merges it with live status from the receiver, transmitter and modem-status logic. The result is one interrupt line and an identification byte. The identification byte names the most urgent pending source, so a driver can read it and service that source first.

The transmit-holding-empty source is the only one this block keeps state for. It has a pending flag with its own set and clear events:

- a read of the identification byte clears it;
- a write to the holding register clears it;
- a transmit-FIFO flush sets it;
- a change of its enable bit either sets it or clears it.

Every other source is combinational in the status inputs, so both the code and the interrupt line follow a status change in the same cycle.

Top module: `uart_irq_prio`

## Requirements
- R1: When enable bit 2 is set and any bit of `err_flags` is 1 (the four error flags are overrun, parity, framing and break), the code in `id_reg[3:0]` is 0x6. This source has the highest priority.
- R2: When enable bit 0 is set and `char_timeout` is 1, with no R1 source active, the code is 0xC. No other enable bit gates this source.
- R3: The received-data code 0x4 is reported when all of the following hold: enable bit 0 is set, `data_ready` is 1, and no R1 or R2 source is active. When `fifo_en` is 1, `rx_count >= rx_trigger` must also hold; when `fifo_en` is 0, `data_ready` alone is enough.
- R4: When enable bit 1 is set and the transmit pending flag is 1, with no higher source active, the code is 0x2.
- R5: When enable bit 3 is set and any bit of `msr_delta` is 1, with no higher source active, the code is 0x0.
- R6: When no source is active, the code is 0x1 and `irq` is 0. Whenever the code is not 0x1, `irq` is 1.
- R7: A pulse on `id_rd` in a cycle where the code is 0x2 clears the transmit pending flag. An `id_rd` pulse while any other code is shown leaves the flag unchanged.
- R8: A write to the enable register that changes bit 1 sets the pending flag if the new bit 1 is 1 and `thr_empty` is 1, and clears the flag otherwise. A write that leaves bit 1 unchanged does not touch the flag.
- R9: A `thr_wr` pulse clears the pending flag. A `txfifo_rst` pulse sets it. When both are pulsed together, the flush wins.
- R10: Bits 7:6 of `id_reg` read 11 when `fifo_en` is 1 and 00 when it is 0. Bits 5:4 always read 0.
- R11: An enable-register write stores `ier_wdata[3:0]` and ignores bits 7:4. The stored value appears on `ier_q` one cycle after the strobe.
- R12: After reset, `ier_q` is 0, the pending flag is 0, `id_reg` is 0x01 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode is on |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| id_rd | input | 1 | Identification-register read strobe |
| thr_wr | input | 1 | Holding-register write strobe |
| txfifo_rst | input | 1 | Transmit-FIFO flush strobe |
| thr_empty | input | 1 | Transmit holding register is empty |
| err_flags | input | 4 | Overrun, parity, framing and break flags |
| data_ready | input | 1 | Receive data is available |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| char_timeout | input | 1 | Character timeout is pending |
| msr_delta | input | 4 | Modem-status delta bits |
| ier_q | output | 4 | Stored enable bits |
| id_reg | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the following hold:

- an enabled line-status error always wins;
- the interrupt line agrees with the reported code;
- the FIFO-mode bits track `fifo_en`;
- an enable write lands one cycle later;
- a read of code 0x2, or a holding-register write, leaves code 0x2 gone in the next cycle.

The full priority order can only be shown by the bench's scenarios. The bench sweeps all enable values against every mix of sources, including the exact trigger-level boundary. The same applies to the pending-flag rules: re-arming on an enable edge, no effect when the enable write keeps bit 1, the empty gate, and a flush winning over a simultaneous write.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             id_rd,
  input  logic             thr_wr,
  input  logic             txfifo_rst,
  input  logic             thr_empty,
  input  logic [3:0]       err_flags,
  input  logic             data_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             char_timeout,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       ier_q,
  output logic [7:0]       id_reg,
  output logic             irq
);

  localparam logic [3:0] C_LINE = 4'h6;
  localparam logic [3:0] C_TOUT = 4'hC;
  localparam logic [3:0] C_RXD  = 4'h4;
  localparam logic [3:0] C_TXE  = 4'h2;
  localparam logic [3:0] C_MDM  = 4'h0;
  localparam logic [3:0] C_NONE = 4'h1;

  logic [3:0] en;
  logic       tx_pend;
  logic [3:0] code;

  wire hit_line = en[2] & (|err_flags);
  wire hit_tout = en[0] & char_timeout;
  wire hit_rxd  = en[0] & data_ready & (~fifo_en | (rx_count >= rx_trigger));
  wire hit_txe  = en[1] & tx_pend;
  wire hit_mdm  = en[3] & (|msr_delta);

  always_comb begin
    if (hit_line)      code = C_LINE;
    else if (hit_tout) code = C_TOUT;
    else if (hit_rxd)  code = C_RXD;
    else if (hit_txe)  code = C_TXE;
    else if (hit_mdm)  code = C_MDM;
    else               code = C_NONE;
  end

  wire en_tx_change = ier_wr & (ier_wdata[1] ^ en[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      tx_pend <= 1'b0;
    end else begin
      if (ier_wr) en <= ier_wdata[3:0];
      if (txfifo_rst)                  tx_pend <= 1'b1;
      else if (thr_wr)                 tx_pend <= 1'b0;
      else if (en_tx_change)           tx_pend <= ier_wdata[1] & thr_empty;
      else if (id_rd && code == C_TXE) tx_pend <= 1'b0;
    end
  end

  assign ier_q  = en;
  assign id_reg = {{2{fifo_en}}, 2'b00, code};
  assign irq    = (code != C_NONE);

endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic       id_rd,
  input logic       thr_wr,
  input logic       txfifo_rst,
  input logic [3:0] err_flags,
  input logic [3:0] ier_q,
  input logic [7:0] id_reg,
  input logic       irq
);

  a_r1_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (|err_flags)) |-> id_reg[3:0] == 4'h6);

  a_r6_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id_reg[3:0] != 4'h1));

  a_r7_read_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && id_reg[3:0] == 4'h2 && !txfifo_rst && !ier_wr) |=> id_reg[3:0] != 4'h2);

  a_r9_write_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !txfifo_rst) |=> id_reg[3:0] != 4'h2);

  a_r10_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
    id_reg[7:4] == {fifo_en, fifo_en, 2'b00});

  a_r11_enable_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_q == $past(ier_wdata[3:0]));

endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier_wr(ier_wr),
  .ier_wdata(ier_wdata), .id_rd(id_rd), .thr_wr(thr_wr),
  .txfifo_rst(txfifo_rst), .err_flags(err_flags), .ier_q(ier_q),
  .id_reg(id_reg), .irq(irq)
);

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, ier_wr = 0, id_rd = 0, thr_wr = 0, txfifo_rst = 0, thr_empty = 0;
  logic [7:0] ier_wdata = '0;
  logic [3:0] err_flags = '0, msr_delta = '0;
  logic data_ready = 0, char_timeout = 0;
  logic [CW-1:0] rx_count = '0, rx_trigger = '0;
  logic [3:0] ier_q;
  logic [7:0] id_reg;
  logic irq;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_irq_prio #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier_wr(ier_wr),
    .ier_wdata(ier_wdata), .id_rd(id_rd), .thr_wr(thr_wr),
    .txfifo_rst(txfifo_rst), .thr_empty(thr_empty), .err_flags(err_flags),
    .data_ready(data_ready), .rx_count(rx_count), .rx_trigger(rx_trigger),
    .char_timeout(char_timeout), .msr_delta(msr_delta), .ier_q(ier_q),
    .id_reg(id_reg), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [3:0] e, input logic pend);
    if (e[2] && |err_flags) return 4'h6;
    if (e[0] && char_timeout) return 4'hC;
    if (e[0] && data_ready && (!fifo_en || rx_count >= rx_trigger)) return 4'h4;
    if (e[1] && pend) return 4'h2;
    if (e[3] && |msr_delta) return 4'h0;
    return 4'h1;
  endfunction

  task automatic pulse_ier(input logic [7:0] d);
    @(negedge clk); ier_wdata = d; ier_wr = 1;
    @(negedge clk); ier_wr = 0;
  endtask
  task automatic pulse_rd;
    @(negedge clk); id_rd = 1;
    @(negedge clk); id_rd = 0;
  endtask
  task automatic pulse_thr(input logic flush, input logic wr);
    @(negedge clk); txfifo_rst = flush; thr_wr = wr;
    @(negedge clk); txfifo_rst = 0; thr_wr = 0;
  endtask
  task automatic quiet;
    @(negedge clk);
    err_flags = 0; char_timeout = 0; data_ready = 0; msr_delta = 0; fifo_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R12 reset state
    #12;
    check("R12 id", id_reg, 8'h01);
    check("R12 irq", {7'd0, irq}, 8'h00);
    check("R12 ier", {4'd0, ier_q}, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R12 id after release", id_reg, 8'h01);

    // Sweep: every enable value against every source mix (R1-R6 each named below)
    thr_empty = 1;
    for (int v = 0; v < 16; v++) begin
      pulse_ier(8'h00);
      pulse_ier(8'(v));
      for (int s = 0; s < 64; s++) begin
        @(negedge clk);
        err_flags    = s[0] ? 4'(1 << ((s + v) % 4)) : 4'h0;
        char_timeout = s[1];
        data_ready   = s[2];
        rx_trigger   = 5'd8;
        rx_count     = s[3] ? 5'd8 : 5'd7;
        fifo_en      = s[4];
        msr_delta    = s[5] ? 4'(1 << (v % 4)) : 4'h0;
        #1;
        // R1 R2 R3 R4 R5 code; R10 mode bits; R6 irq
        check("R1/R2/R3/R4/R5 code", id_reg,
              {{2{fifo_en}}, 2'b00, model(4'(v), v[1])});
        check("R6 irq", {7'd0, irq}, {7'd0, model(4'(v), v[1]) != 4'h1});
      end
      quiet();
    end

    // R3 boundary: count above and below trigger
    pulse_ier(8'h01);
    @(negedge clk); fifo_en = 1; data_ready = 1; rx_trigger = 5'd14; rx_count = 5'd13; #1;
    check("R3 below trigger", id_reg, 8'hC1);
    rx_count = 5'd16; #1;
    check("R3 above trigger", id_reg, 8'hC4);
    fifo_en = 0; rx_count = 5'd0; #1;
    check("R3 no fifo", id_reg, 8'h04);
    quiet();

    // R11 upper bits ignored
    pulse_ier(8'hF0);
    check("R11 upper ignored", {4'd0, ier_q}, 8'h00);
    pulse_ier(8'hA5);
    check("R11 low kept", {4'd0, ier_q}, 8'h05);

    // R8 rise with empty -> armed; R7 read clears
    thr_empty = 1;
    pulse_ier(8'h00);
    pulse_ier(8'h02);
    check("R8 armed", id_reg, 8'h02);
    pulse_ier(8'h03);
    check("R8 same bit keeps flag", id_reg, 8'h02);
    pulse_rd();
    check("R7 read clears", id_reg, 8'h01);
    check("R7 irq low", {7'd0, irq}, 8'h00);

    // R7 read while another code shown leaves flag
    pulse_thr(1, 0);
    @(negedge clk); err_flags = 4'h1;
    pulse_ier(8'h06);
    pulse_rd();
    @(negedge clk); err_flags = 0; #1;
    check("R7 other code keeps flag", id_reg, 8'h02);

    // R8 rise with non-empty -> not armed; fall clears
    pulse_ier(8'h00);
    thr_empty = 0;
    pulse_ier(8'h02);
    check("R8 not empty", id_reg, 8'h01);
    pulse_thr(1, 0);
    check("R9 flush sets", id_reg, 8'h02);
    pulse_ier(8'h00);
    pulse_ier(8'h02);
    check("R8 fall clears", id_reg, 8'h01);

    // R9 write clears, flush wins
    pulse_thr(1, 0);
    pulse_thr(0, 1);
    check("R9 write clears", id_reg, 8'h01);
    pulse_thr(1, 1);
    check("R9 flush wins", id_reg, 8'h02);

    // R12 reset again
    @(negedge clk); rst_n = 0; #1;
    check("R12 re-reset id", id_reg, 8'h01);
    check("R12 re-reset ier", {4'd0, ier_q}, 8'h00);
    @(negedge clk); rst_n = 1;
    pulse_ier(8'h02);
    check("R12 flag cleared", id_reg, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule